// File: doc/BRIEF.md
# SPI Multi-Frame Data Buffer

This block is the data-register stage between a host bus and the shift engine of an SPI master. A host writes transmit frames into a small transmit queue. The shift engine takes those frames one at a time, and each frame it returns is stored in a receive queue. The host reads the receive queue back through the same data register. Each queue raises its status once it holds a programmable number of frames, from one to four. That number is set by a 2-bit frame-count code.

Several bits on the configuration side shape the behaviour:
- A readback-select bit switches data-register reads between receive data and the last accepted transmit word.
- An access-width bit chooses 16-bit or 32-bit data.
- A 3-bit command-sequence length is checked against the frame count.
- The frame data length is checked against the access width.

Any illegal setting latches a configuration error, and the error stops all transfers. The shift engine is modelled only as a frame-done strobe together with a receive-data word.

Top module: `spi_frame_buf`

## Requirements
- R1: After reset the outputs read as follows: `tx_empty_o`=1, `rx_full_o`=0, `tx_ready_o`=0, `ovr_err_o`=0 and `cfg_err_o`=0. With `rd_sel_tx_i`=0, `rdata_o` is 0.
- R2: The threshold is `frame_cnt_i`+1: code 00 means 1 frame and code 11 means 4 frames. A write is accepted while the transmit queue holds fewer frames than the threshold, and one cycle later `tx_empty_o` is 0.
- R3: A write is ignored when the transmit queue already holds the threshold number of frames, counted before that cycle. An ignored write changes neither the queue nor the readback word. It sets `ovr_err_o`, which then stays set until reset.
- R4: `tx_data_o` presents the oldest queued transmit frame. `tx_ready_o` is 1 when all of these hold: the transmit queue is non-empty, `rx_full_o` is 0 and `cfg_err_o` is 0. A `frame_done_i` pulse while `tx_ready_o` is 1 removes that frame and stores `rx_data_i` in the receive queue. When `tx_ready_o` is 0, `frame_done_i` is ignored.
- R5: `tx_empty_o` is 1 exactly when every queued transmit frame has been consumed.
- R6: `rx_full_o` sets when a stored frame brings the receive count to the threshold or above.
- R7: A read with `rd_sel_tx_i`=0 returns the oldest received frame and removes it, so frames come back in arrival order. `rx_full_o` clears once the receive queue is empty. A read of an empty receive queue returns 0.
- R8: With `rd_sel_tx_i`=1, `rdata_o` returns the most recently accepted write, and reads do not disturb the receive queue.
- R9: With `long_mode_i`=0, written words keep bits 15:0 and bits 31:16 are cleared. Receive data is returned with bits 31:16 at 0. With `long_mode_i`=1, all 32 bits pass through.
- R10: Each sequence-length code from 000 to 111 stands for 1 to 8 commands. The legal pairings with the frame-count code are:
  - 000 with any frame-count code.
  - 001 with 01 or 11.
  - 010 with 10.
  - 011 with 11.
  - 100 to 111 with 00.

  Any other pairing sets `cfg_err_o` on the next clock edge.
- R11: `data_bits_i` gives the frame length in bits. The legal range is 8 to 32 when `long_mode_i`=1 and 8 to 16 when `long_mode_i`=0. Any other value sets `cfg_err_o`.
- R12: `cfg_err_o` stays set until reset, even after the configuration becomes legal again. While it is set, `tx_ready_o` is 0 and `frame_done_i` has no effect.
- R13: A write and a frame-done pulse in the same cycle both take effect. Whether the write is accepted is decided on the transmit count before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seq_len_i | input | 3 | Command-sequence length code (length minus one) |
| frame_cnt_i | input | 2 | Frame-count code (threshold minus one) |
| long_mode_i | input | 1 | 1 selects 32-bit access, 0 selects 16-bit access |
| data_bits_i | input | 6 | Frame data length in bits |
| rd_sel_tx_i | input | 1 | 1 makes reads return the last accepted write |
| wr_en_i | input | 1 | Data-register write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Data-register read strobe |
| rdata_o | output | 32 | Read data |
| frame_done_i | input | 1 | Shift engine finished one frame |
| rx_data_i | input | 32 | Frame received by the shift engine |
| tx_data_o | output | 32 | Oldest queued transmit frame |
| tx_ready_o | output | 1 | A frame may be shifted |
| tx_empty_o | output | 1 | Transmit queue empty |
| rx_full_o | output | 1 | Receive queue has reached the threshold |
| ovr_err_o | output | 1 | Sticky: a write was dropped |
| cfg_err_o | output | 1 | Sticky: an illegal configuration was seen |

## Verification
Two pairs of events can fall in the same cycle. In the first, the shift engine consumes a transmit frame while the host writes a new one. In the second, the host reads a receive frame while the engine stores a new one. Random bursts drive write, read and frame-done strobes independently, which makes both collisions frequent. Directed cases pin the write/frame-done collision at a full queue and at a half-full queue. A reference model in the bench judges every cycle, deciding acceptance on the pre-cycle count and popping before pushing.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  localparam int SEQ_W = 3;
  localparam int FC_W  = 2;

  function automatic logic pair_legal(logic [SEQ_W-1:0] seq, logic [FC_W-1:0] fc);
    case (seq)
      3'd0:    return 1'b1;
      3'd1:    return (fc == 2'd1) || (fc == 2'd3);
      3'd2:    return fc == 2'd2;
      3'd3:    return fc == 2'd3;
      default: return fc == 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/sfb_cfg_chk.sv
module sfb_cfg_chk
  import sfb_pkg::*;
#(
  parameter int LW = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEQ_W-1:0] seq_len_i,
  input  logic [FC_W-1:0]  frame_cnt_i,
  input  logic             long_mode_i,
  input  logic [LW-1:0]    data_bits_i,
  output logic             cfg_err_o
);
  logic len_ok, bad, err_q;

  always_comb begin
    len_ok = (data_bits_i >= LW'(8)) &&
             (data_bits_i <= (long_mode_i ? LW'(32) : LW'(16)));
    bad    = !len_ok || !pair_legal(seq_len_i, frame_cnt_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  err_q <= 1'b0;
    else if (bad) err_q <= 1'b1;
  end

  assign cfg_err_o = err_q;
endmodule

// File: rtl/sfb_fifo.sv
module sfb_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  din_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[i] <= '0;
      else if (push_i && wp_q == AW'(i))    mem_q[i] <= din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= inc(wp_q);
      if (pop_i)  rp_q <= inc(rp_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + CW'(1);
      else if (pop_i && !push_i) cnt_q <= cnt_q - CW'(1);
    end
  end

  assign dout_o = mem_q[rp_q];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/spi_frame_buf.sv
module spi_frame_buf
  import sfb_pkg::*;
#(
  parameter int DW    = 32,
  parameter int WW    = 16,
  parameter int DEPTH = 4,
  parameter int LW    = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEQ_W-1:0] seq_len_i,
  input  logic [FC_W-1:0]  frame_cnt_i,
  input  logic             long_mode_i,
  input  logic [LW-1:0]    data_bits_i,
  input  logic             rd_sel_tx_i,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             rd_en_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             frame_done_i,
  input  logic [DW-1:0]    rx_data_i,
  output logic [DW-1:0]    tx_data_o,
  output logic             tx_ready_o,
  output logic             tx_empty_o,
  output logic             rx_full_o,
  output logic             ovr_err_o,
  output logic             cfg_err_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] thr, tx_cnt, rx_cnt, rx_cnt_nx;
  logic [DW-1:0] tx_head, rx_head, wr_word, last_q;
  logic          wr_ok, xfer, rx_push, rx_pop, cfg_err;
  logic          ovr_q, rx_full_q;

  function automatic logic [DW-1:0] fit(logic [DW-1:0] x, logic lng);
    return lng ? x : DW'(x[WW-1:0]);
  endfunction

  always_comb begin
    thr        = CW'(frame_cnt_i) + CW'(1);
    wr_word    = fit(wdata_i, long_mode_i);
    wr_ok      = wr_en_i && (tx_cnt < thr);
    tx_ready_o = (tx_cnt != '0) && !rx_full_q && !cfg_err;
    xfer       = frame_done_i && tx_ready_o;
    rx_push    = xfer && (rx_cnt < CW'(DEPTH));
    rx_pop     = rd_en_i && !rd_sel_tx_i && (rx_cnt != '0);
    rx_cnt_nx  = rx_cnt + CW'(rx_push) - CW'(rx_pop);
  end

  sfb_fifo #(.W(DW), .DEPTH(DEPTH)) u_tx_q (
    .clk_i, .rst_ni,
    .push_i(wr_ok), .pop_i(xfer), .din_i(wr_word),
    .dout_o(tx_head), .cnt_o(tx_cnt)
  );

  sfb_fifo #(.W(DW), .DEPTH(DEPTH)) u_rx_q (
    .clk_i, .rst_ni,
    .push_i(rx_push), .pop_i(rx_pop), .din_i(rx_data_i),
    .dout_o(rx_head), .cnt_o(rx_cnt)
  );

  sfb_cfg_chk #(.LW(LW)) u_cfg (
    .clk_i, .rst_ni,
    .seq_len_i, .frame_cnt_i, .long_mode_i, .data_bits_i,
    .cfg_err_o(cfg_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q     <= 1'b0;
      rx_full_q <= 1'b0;
      last_q    <= '0;
    end else begin
      if (wr_en_i && !wr_ok) ovr_q <= 1'b1;
      if (wr_ok)             last_q <= wr_word;
      if (rx_cnt_nx == '0)                      rx_full_q <= 1'b0;
      else if (rx_push && (rx_cnt_nx >= thr))   rx_full_q <= 1'b1;
    end
  end

  always_comb begin
    if (rd_sel_tx_i)         rdata_o = last_q;
    else if (rx_cnt != '0)   rdata_o = fit(rx_head, long_mode_i);
    else                     rdata_o = '0;
  end

  assign tx_data_o  = tx_head;
  assign tx_empty_o = (tx_cnt == '0);
  assign rx_full_o  = rx_full_q;
  assign ovr_err_o  = ovr_q;
  assign cfg_err_o  = cfg_err;
endmodule

// File: rtl/sfb_chk.sv
module sfb_chk #(
  parameter int DW = 32,
  parameter int WW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          long_mode_i,
  input logic          rd_sel_tx_i,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic [DW-1:0] rdata_o,
  input logic          tx_ready_o,
  input logic          tx_empty_o,
  input logic          rx_full_o,
  input logic          ovr_err_o,
  input logic          cfg_err_o
);
  assert_ovr_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_err_o |=> ovr_err_o);

  assert_ovr_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_err_o) |-> $past(wr_en_i));

  assert_cfg_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);

  assert_cfg_blocks_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !tx_ready_o);

  assert_empty_not_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> !tx_ready_o);

  assert_empty_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_empty_o && !wr_en_i) |=> tx_empty_o);

  assert_full_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_o && !(rd_en_i && !rd_sel_tx_i)) |=> rx_full_o);

  assert_full_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_o |-> !tx_ready_o);

  assert_word_upper_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !long_mode_i |-> (rdata_o[DW-1:WW] == '0));
endmodule

bind spi_frame_buf sfb_chk #(.DW(DW), .WW(WW)) u_sfb_chk (.*);

// File: tb/tb_spi_frame_buf.sv
`timescale 1ns/1ps
module tb_spi_frame_buf;
  localparam time TCK = 20ns;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [2:0]  seq_len_i = '0;
  logic [1:0]  frame_cnt_i = '0;
  logic        long_mode_i = 1'b1;
  logic [5:0]  data_bits_i = 6'd32;
  logic        rd_sel_tx_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0, frame_done_i = 1'b0;
  logic [31:0] wdata_i = '0, rx_data_i = '0;
  logic [31:0] rdata_o, tx_data_o;
  logic        tx_ready_o, tx_empty_o, rx_full_o, ovr_err_o, cfg_err_o;

  int n_chk = 0, n_bad = 0;

  logic [31:0] mtx[$], mrx[$], mlast;
  logic        movr, mfull;

  spi_frame_buf dut (.*);

  always #(TCK/2) clk_i = ~clk_i;

  function automatic logic [31:0] fitw(logic [31:0] x, logic lng);
    return lng ? x : {16'h0, x[15:0]};
  endfunction

  function automatic logic exp_pair(int s, int f);
    if (s == 0) return 1'b1;
    if (s == 1) return (f == 1) || (f == 3);
    if (s == 2) return f == 2;
    if (s == 3) return f == 3;
    return f == 0;
  endfunction

  function automatic logic exp_len(logic lng, int b);
    return (b >= 8) && (b <= (lng ? 32 : 16));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle();
    wr_en_i = 0; rd_en_i = 0; frame_done_i = 0; rd_sel_tx_i = 0;
  endtask

  task automatic do_reset();
    idle();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    mtx.delete(); mrx.delete();
    mlast = '0; movr = 0; mfull = 0;
  endtask

  task automatic set_cfg(int s, int f, logic lng, int b);
    seq_len_i = 3'(s); frame_cnt_i = 2'(f); long_mode_i = lng; data_bits_i = 6'(b);
  endtask

  task automatic cmp_model();
    int thr;
    thr = int'(frame_cnt_i) + 1;
    chk("R5", 32'(tx_empty_o), 32'(mtx.size() == 0));
    chk("R6", 32'(rx_full_o), 32'(mfull));
    chk("R3", 32'(ovr_err_o), 32'(movr));
    chk("R4", 32'(tx_ready_o), 32'((mtx.size() != 0) && !mfull));
    if (mtx.size() != 0) chk("R4", tx_data_o, mtx[0]);
    if (rd_sel_tx_i) chk("R8", rdata_o, mlast);
    else chk("R7", rdata_o, (mrx.size() != 0) ? fitw(mrx[0], long_mode_i) : 32'h0);
    if (thr < 1) n_bad++;
  endtask

  task automatic model_step();
    int thr, n;
    logic wok, xf, rp;
    thr = int'(frame_cnt_i) + 1;
    wok = wr_en_i && (mtx.size() < thr);
    xf  = frame_done_i && (mtx.size() != 0) && !mfull;
    rp  = rd_en_i && !rd_sel_tx_i && (mrx.size() != 0);
    if (wr_en_i && !wok) movr = 1;
    if (xf) void'(mtx.pop_front());
    if (wok) begin
      mtx.push_back(fitw(wdata_i, long_mode_i));
      mlast = fitw(wdata_i, long_mode_i);
    end
    if (rp) void'(mrx.pop_front());
    if (xf) mrx.push_back(rx_data_i);
    n = mrx.size();
    if (n == 0) mfull = 0;
    else if (xf && n >= thr) mfull = 1;
  endtask

  initial begin
    #(TCK * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 act=hung exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk_i);

    // R1 reset state
    set_cfg(0, 0, 1, 32);
    do_reset();
    chk("R1", 32'(tx_empty_o), 32'd1);
    chk("R1", 32'(rx_full_o), 32'd0);
    chk("R1", 32'(tx_ready_o), 32'd0);
    chk("R1", 32'(ovr_err_o), 32'd0);
    chk("R1", 32'(cfg_err_o), 32'd0);
    chk("R1", rdata_o, 32'h0);

    // R2 / R3: single-frame threshold, second write dropped
    wr_en_i = 1; wdata_i = 32'hA5A5_0001; tick();
    chk("R2", 32'(tx_empty_o), 32'd0);
    wdata_i = 32'h5A5A_0002; tick();
    wr_en_i = 0; rd_sel_tx_i = 1; #1;
    chk("R3", 32'(ovr_err_o), 32'd1);
    chk("R3", rdata_o, 32'hA5A5_0001);
    chk("R3", tx_data_o, 32'hA5A5_0001);

    // R9 word access
    set_cfg(0, 0, 0, 16);
    do_reset();
    wr_en_i = 1; wdata_i = 32'hDEAD_BEEF; tick();
    wr_en_i = 0; rd_sel_tx_i = 1; #1;
    chk("R9", rdata_o, 32'h0000_BEEF);
    chk("R9", tx_data_o, 32'h0000_BEEF);
    rd_sel_tx_i = 0; frame_done_i = 1; rx_data_i = 32'h1234_5678; tick();
    frame_done_i = 0; #1;
    chk("R9", rdata_o, 32'h0000_5678);

    // R13 collision at full queue (threshold 1)
    set_cfg(0, 0, 1, 32);
    do_reset();
    wr_en_i = 1; wdata_i = 32'h1111_1111; tick();
    wdata_i = 32'h2222_2222; frame_done_i = 1; rx_data_i = 32'hCAFE_0001; tick();
    idle(); #1;
    chk("R13", 32'(tx_empty_o), 32'd1);
    chk("R13", 32'(ovr_err_o), 32'd1);
    chk("R13", 32'(rx_full_o), 32'd1);
    chk("R13", rdata_o, 32'hCAFE_0001);
    rd_en_i = 1; tick(); idle(); #1;
    chk("R7", 32'(rx_full_o), 32'd0);
    chk("R7", rdata_o, 32'h0);

    // R13 collision at half-full queue (threshold 2)
    set_cfg(0, 1, 1, 32);
    do_reset();
    wr_en_i = 1; wdata_i = 32'h3333_3333; tick();
    wdata_i = 32'h4444_4444; frame_done_i = 1; tick();
    idle(); #1;
    chk("R13", 32'(tx_empty_o), 32'd0);
    chk("R13", 32'(ovr_err_o), 32'd0);
    chk("R13", tx_data_o, 32'h4444_4444);
    chk("R13", 32'(rx_full_o), 32'd0);

    // R10 every sequence/frame pairing
    for (int s = 0; s < 8; s++) begin
      for (int f = 0; f < 4; f++) begin
        set_cfg(s, f, 1, 32);
        do_reset();
        tick();
        chk("R10", 32'(cfg_err_o), 32'(!exp_pair(s, f)));
      end
    end

    // R11 data length against access width
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 8; k++) begin
        int b;
        case (k)
          0: b = 7;  1: b = 8;  2: b = 16; 3: b = 17;
          4: b = 20; 5: b = 24; 6: b = 32; default: b = 33;
        endcase
        set_cfg(0, 0, 1'(m), b);
        do_reset();
        tick();
        chk("R11", 32'(cfg_err_o), 32'(!exp_len(1'(m), b)));
      end
    end

    // R12 sticky error blocks transfers
    set_cfg(2, 0, 1, 32);
    do_reset();
    tick();
    chk("R12", 32'(cfg_err_o), 32'd1);
    set_cfg(2, 2, 1, 32);
    wr_en_i = 1; wdata_i = 32'h7777_0000; tick();
    wr_en_i = 0; frame_done_i = 1; tick();
    frame_done_i = 0; #1;
    chk("R12", 32'(cfg_err_o), 32'd1);
    chk("R12", 32'(tx_ready_o), 32'd0);
    chk("R12", 32'(tx_empty_o), 32'd0);
    chk("R12", rdata_o, 32'h0);

    // random phases over legal configurations
    for (int c = 0; c < 8; c++) begin
      int fc, sq;
      logic lng;
      fc  = c % 4;
      lng = 1'((c / 2) % 2);
      case (c)
        4: sq = 7; 5: sq = 1; 6: sq = 2; 7: sq = 3; default: sq = 0;
      endcase
      set_cfg(sq, fc, lng, lng ? 32 : 16);
      do_reset();
      for (int i = 0; i < 400; i++) begin
        cmp_model();
        wr_en_i      = ($urandom % 100) < 40;
        rd_en_i      = ($urandom % 100) < 40;
        frame_done_i = ($urandom % 100) < 45;
        rd_sel_tx_i  = ($urandom % 100) < 25;
        wdata_i      = $urandom;
        rx_data_i    = $urandom;
        model_step();
        @(negedge clk_i);
      end
      idle();
      chk("R12", 32'(cfg_err_o), 32'd0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule